// File: doc/BRIEF.md
# Indirect-Addressed SCSI Controller Register Front End

This block is the host-facing register interface of a small SCSI bus-interface controller. The host sees only two byte-wide ports inside an eight-byte window. The address/status port sits at offset 3 and the data port at offset 7. Writing the address/status port chooses one of 32 internal byte registers. Reading it returns an auxiliary status byte. Every data-port access goes to the register the pointer names, and each data-port write moves the pointer on by one.

A few commands written to the command register have side effects. Reset, select-with-attention and transfer-info manage an interrupt-pending flag and load a status-code register. The result of a selection depends on a per-target presence input. During transfer-info the block counts the bytes written to the data register against a 24-bit count. When the count is reached it raises the interrupt and reports the phase given by a direction input.

Read data comes back on `rd_data` with `rd_valid` high, one cycle after the access. The host side has no back-pressure: every access is taken in the cycle `acc_en` is high. A read response must be consumed in the cycle it is shown, because it is never held.

Top module: `scsi_regif`

## Requirements
- R1: A synchronous active-high reset clears the pointer, the interrupt flag, the transfer counter and all 32 registers. After reset `irq` is 0 and every register reads 0x00.
- R2: An access is decoded only at offset 3 (address/status port) and offset 7 (data port), so the port index is bit 2 of the offset. An access at any other offset changes nothing and produces no read response.
- R3: A write to the address/status port loads the pointer with the low 5 bits of the byte, so 0x23 selects register 0x03.
- R4: A read of the address/status port returns 0x01 when no interrupt is pending and 0x81 when one is pending (bit 7 = interrupt, bit 0 = buffer ready, always 1).
- R5: A read of the data port returns the register under the pointer, one cycle later with `rd_valid` high. Reads never move the pointer.
- R6: A data-port write stores the byte at the pointer and then increments the pointer. The pointer wraps from 0x1F to 0x00.
- R7: A data-port read of the status-code register (0x17) clears the pending interrupt. A read of any other register leaves it unchanged.
- R8: A write to the control register (0x01) with bit 3 set clears the pending interrupt. A control write with bit 3 clear leaves it unchanged.
- R9: Writing command 0x00 (reset) to the command register (0x18) sets the interrupt and loads status code 0x01.
- R10: Writing command 0x06 (select with attention) sets the interrupt. It loads status code 0x8A when `tgt_present` is high for the ID in bits 2:0 of the select-ID register (0x15). Otherwise it loads 0x42 (selection timeout).
- R11: Writing command 0x20 (transfer info) latches the count {0x12, 0x13, 0x14} as high, middle and low bytes, zeroes the byte index and clears the interrupt. Bit 7 of the command byte is ignored, so 0xA0 acts the same.
- R12: During a transfer, each write to the data register (0x19) advances the byte index. The write that makes the index equal the count sets the interrupt and loads status code 0x18 when `dir_out` is 1 or 0x19 when it is 0. No earlier write changes the interrupt.
- R13: Once a transfer has completed, further data-register writes do not set the interrupt again until a new transfer-info command is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Host access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | 3 | Byte offset inside the device window |
| acc_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read response valid (no back-pressure) |
| rd_data | output | 8 | Read response byte |
| tgt_present | input | 8 | Per-target presence, indexed by target ID |
| dir_out | input | 1 | Transfer direction reported at completion (1 = out) |
| irq | output | 1 | Interrupt, equal to the pending flag |

## Verification
Two things can happen in the same cycle. The last byte of a transfer is stored and advances the pointer, and in that very cycle the counter completes, loading the status code and raising the interrupt. Likewise, a command write lands in register 0x18 in the same cycle that its decode overwrites the status code and the pointer steps onto the data register. The bench provokes both with transfers of 3 and 258 bytes, in both directions, and with the transfer-info command sent with and without bit 7. It judges them by checking that `irq` stays low up to the final byte and rises exactly after it. It then reads back the status code, the stored data byte and the pointer position through the data port.

// File: rtl/scsi_regif_pkg.sv
package scsi_regif_pkg;
  localparam int unsigned PTR_W   = 5;
  localparam int unsigned ID_W    = 3;
  localparam int unsigned BYTE_W  = 8;

  // register addresses (pointer values)
  localparam logic [PTR_W-1:0] RA_CTRL    = 5'h01;
  localparam logic [PTR_W-1:0] RA_CNT_HI  = 5'h12;
  localparam logic [PTR_W-1:0] RA_CNT_MID = 5'h13;
  localparam logic [PTR_W-1:0] RA_CNT_LO  = 5'h14;
  localparam logic [PTR_W-1:0] RA_SELID   = 5'h15;
  localparam logic [PTR_W-1:0] RA_STATUS  = 5'h17;
  localparam logic [PTR_W-1:0] RA_CMD     = 5'h18;
  localparam logic [PTR_W-1:0] RA_DATA    = 5'h19;

  // command opcodes (bit 7 is a modifier and is not part of the opcode)
  localparam logic [6:0] OP_RESET   = 7'h00;
  localparam logic [6:0] OP_SEL_ATN = 7'h06;
  localparam logic [6:0] OP_XFER    = 7'h20;

  // status codes
  localparam logic [7:0] SC_RESET_DONE = 8'h01;
  localparam logic [7:0] SC_SEL_TMO    = 8'h42;
  localparam logic [7:0] SC_SVC_REQ    = 8'h88;
  localparam logic [7:0] SC_XFER_DONE  = 8'h18;
  localparam logic [2:0] PH_CMD        = 3'd2;
  localparam logic [2:0] PH_DOUT       = 3'd0;
  localparam logic [2:0] PH_DIN        = 3'd1;

  localparam int unsigned CTRL_EDI_BIT = 3;
  localparam int unsigned ASR_INT_BIT  = 7;
  localparam int unsigned ASR_DBR_BIT  = 0;

  typedef struct packed {
    logic addr_wr;
    logic addr_rd;
    logic data_wr;
    logic data_rd;
  } port_acc_t;
endpackage

// File: rtl/scsi_regif_decode.sv
module scsi_regif_decode
  import scsi_regif_pkg::*;
(
  input  logic       acc_en,
  input  logic       acc_wr,
  input  logic [2:0] acc_off,
  output port_acc_t  acc
);
  logic hit;
  assign hit = acc_en && (acc_off[1:0] == 2'b11);

  always_comb begin
    acc.addr_wr = hit && !acc_off[2] &&  acc_wr;
    acc.addr_rd = hit && !acc_off[2] && !acc_wr;
    acc.data_wr = hit &&  acc_off[2] &&  acc_wr;
    acc.data_rd = hit &&  acc_off[2] && !acc_wr;
  end
endmodule

// File: rtl/scsi_regif_regs.sv
module scsi_regif_regs
  import scsi_regif_pkg::*;
#(
  parameter int unsigned AW = PTR_W,
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ptr_load,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          sc_load,
  input  logic [DW-1:0] sc_val,
  output logic [AW-1:0] ptr,
  output logic [DW-1:0] rd_byte,
  output logic [DW-1:0] cnt_hi,
  output logic [DW-1:0] cnt_mid,
  output logic [DW-1:0] cnt_lo,
  output logic [DW-1:0] selid,
  output logic [DW-1:0] cmd
);
  localparam int unsigned NREGS = 1 << AW;

  logic [DW-1:0] mem [NREGS];
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else begin
      if (ptr_load) ptr_q <= wdata[AW-1:0];
      if (wr_en) begin
        mem[ptr_q] <= wdata;
        ptr_q      <= ptr_q + 1'b1;
      end
      if (sc_load) mem[RA_STATUS] <= sc_val;
    end
  end

  assign ptr     = ptr_q;
  assign rd_byte = mem[ptr_q];
  assign cnt_hi  = mem[RA_CNT_HI];
  assign cnt_mid = mem[RA_CNT_MID];
  assign cnt_lo  = mem[RA_CNT_LO];
  assign selid   = mem[RA_SELID];
  assign cmd     = mem[RA_CMD];
endmodule

// File: rtl/scsi_regif_xfer.sv
module scsi_regif_xfer #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             beat,
  output logic             done
);
  logic             armed_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx_nxt;

  assign idx_nxt = idx_q + 1'b1;
  assign done    = beat && armed_q && (idx_nxt == cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else if (start) begin
      armed_q <= 1'b1;
      idx_q   <= '0;
      cnt_q   <= cnt_in;
    end else if (stop) begin
      armed_q <= 1'b0;
    end else if (beat && armed_q) begin
      idx_q <= idx_nxt;
      if (done) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/scsi_regif_cmd.sv
module scsi_regif_cmd
  import scsi_regif_pkg::*;
#(
  parameter int unsigned NTGT = 1 << ID_W
) (
  input  port_acc_t        acc,
  input  logic [PTR_W-1:0] ptr,
  input  logic [7:0]       wdata,
  input  logic [7:0]       selid,
  input  logic [7:0]       cmd_reg,
  input  logic [NTGT-1:0]  tgt_present,
  input  logic             dir_out,
  input  logic             xfer_done,
  output logic             irq_set,
  output logic             irq_clr,
  output logic             sc_load,
  output logic [7:0]       sc_val,
  output logic             xfer_start,
  output logic             xfer_stop,
  output logic             xfer_beat
);
  logic       cmd_wr;
  logic [6:0] op;
  logic       tgt_hit;

  assign cmd_wr  = acc.data_wr && (ptr == RA_CMD);
  assign op      = wdata[6:0];
  assign tgt_hit = tgt_present[selid[ID_W-1:0]];

  assign xfer_beat = acc.data_wr && (ptr == RA_DATA) && (cmd_reg[6:0] == OP_XFER);

  always_comb begin
    irq_set    = 1'b0;
    irq_clr    = 1'b0;
    sc_load    = 1'b0;
    sc_val     = '0;
    xfer_start = 1'b0;
    xfer_stop  = 1'b0;

    if (cmd_wr) begin
      xfer_stop = (op != OP_XFER);
      case (op)
        OP_RESET: begin
          irq_set = 1'b1;
          sc_load = 1'b1;
          sc_val  = SC_RESET_DONE;
        end
        OP_SEL_ATN: begin
          irq_set = 1'b1;
          sc_load = 1'b1;
          sc_val  = tgt_hit ? (SC_SVC_REQ | {5'd0, PH_CMD}) : SC_SEL_TMO;
        end
        OP_XFER: begin
          irq_clr    = 1'b1;
          xfer_start = 1'b1;
        end
        default: ;
      endcase
    end

    if (acc.data_wr && (ptr == RA_CTRL) && wdata[CTRL_EDI_BIT]) irq_clr = 1'b1;
    if (acc.data_rd && (ptr == RA_STATUS)) irq_clr = 1'b1;

    if (xfer_done) begin
      irq_set = 1'b1;
      sc_load = 1'b1;
      sc_val  = SC_XFER_DONE | {5'd0, (dir_out ? PH_DOUT : PH_DIN)};
    end
  end
endmodule

// File: rtl/scsi_regif.sv
module scsi_regif
  import scsi_regif_pkg::*;
#(
  parameter int unsigned CNT_BYTES = 3,
  parameter int unsigned NTGT      = 1 << ID_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc_en,
  input  logic            acc_wr,
  input  logic [2:0]      acc_off,
  input  logic [7:0]      acc_wdata,
  output logic            rd_valid,
  output logic [7:0]      rd_data,
  input  logic [NTGT-1:0] tgt_present,
  input  logic            dir_out,
  output logic            irq
);
  localparam int unsigned CNT_W = CNT_BYTES * BYTE_W;

  port_acc_t        acc;
  logic [PTR_W-1:0] ptr_w;
  logic [7:0]       rd_byte, cnt_hi, cnt_mid, cnt_lo, selid, cmd_reg;
  logic             irq_set, irq_clr, sc_load;
  logic [7:0]       sc_val;
  logic             xfer_start, xfer_stop, xfer_beat, xfer_done;
  logic             irq_q, rd_valid_q;
  logic [7:0]       rd_data_q, asr;

  scsi_regif_decode u_dec (
    .acc_en (acc_en), .acc_wr (acc_wr), .acc_off (acc_off), .acc (acc)
  );

  scsi_regif_regs #(.AW(PTR_W), .DW(BYTE_W)) u_regs (
    .clk (clk), .rst (rst),
    .ptr_load (acc.addr_wr), .wr_en (acc.data_wr), .wdata (acc_wdata),
    .sc_load (sc_load), .sc_val (sc_val),
    .ptr (ptr_w), .rd_byte (rd_byte),
    .cnt_hi (cnt_hi), .cnt_mid (cnt_mid), .cnt_lo (cnt_lo),
    .selid (selid), .cmd (cmd_reg)
  );

  scsi_regif_cmd #(.NTGT(NTGT)) u_cmd (
    .acc (acc), .ptr (ptr_w), .wdata (acc_wdata),
    .selid (selid), .cmd_reg (cmd_reg),
    .tgt_present (tgt_present), .dir_out (dir_out), .xfer_done (xfer_done),
    .irq_set (irq_set), .irq_clr (irq_clr),
    .sc_load (sc_load), .sc_val (sc_val),
    .xfer_start (xfer_start), .xfer_stop (xfer_stop), .xfer_beat (xfer_beat)
  );

  scsi_regif_xfer #(.CNT_W(CNT_W)) u_xfer (
    .clk (clk), .rst (rst),
    .start (xfer_start), .stop (xfer_stop),
    .cnt_in ({cnt_hi, cnt_mid, cnt_lo}),
    .beat (xfer_beat), .done (xfer_done)
  );

  always_comb begin
    asr = '0;
    asr[ASR_DBR_BIT] = 1'b1;
    asr[ASR_INT_BIT] = irq_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      if (irq_set)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
      rd_valid_q <= acc.addr_rd || acc.data_rd;
      rd_data_q  <= acc.addr_rd ? asr : (acc.data_rd ? rd_byte : 8'h00);
    end
  end

  assign irq      = irq_q;
  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/scsi_regif_chk.sv
module scsi_regif_chk #(
  parameter int unsigned PW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_en,
  input logic          acc_wr,
  input logic [2:0]    acc_off,
  input logic [7:0]    acc_wdata,
  input logic          rd_valid,
  input logic [7:0]    rd_data,
  input logic          irq,
  input logic [PW-1:0] ptr
);
  logic addr_wr_c, addr_rd_c, data_wr_c, data_rd_c, off_miss;
  assign addr_wr_c = acc_en &&  acc_wr && (acc_off == 3'd3);
  assign addr_rd_c = acc_en && !acc_wr && (acc_off == 3'd3);
  assign data_wr_c = acc_en &&  acc_wr && (acc_off == 3'd7);
  assign data_rd_c = acc_en && !acc_wr && (acc_off == 3'd7);
  assign off_miss  = acc_en && (acc_off[1:0] != 2'b11);

  AST_RESET_IRQ_LOW: assert property (@(posedge clk) rst |=> !irq && !rd_valid); // R1
  AST_OFF_IGNORED: assert property (@(posedge clk) disable iff (rst)
    off_miss |=> $stable(ptr) && !rd_valid); // R2
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    addr_wr_c |=> ptr == $past(acc_wdata[PW-1:0])); // R3
  AST_ASR_FORMAT: assert property (@(posedge clk) disable iff (rst)
    addr_rd_c |=> rd_valid && rd_data == {$past(irq), 6'd0, 1'b1}); // R4
  AST_READ_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
    data_rd_c |=> rd_valid && $stable(ptr)); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    data_wr_c |=> ptr == PW'($past(ptr) + 1'b1)); // R6
  AST_SC_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    data_rd_c && ptr == PW'(5'h17) |=> !irq); // R7
  AST_EDI_CLEARS: assert property (@(posedge clk) disable iff (rst)
    data_wr_c && ptr == PW'(5'h01) && acc_wdata[3] |=> !irq); // R8
  AST_RESET_CMD_IRQ: assert property (@(posedge clk) disable iff (rst)
    data_wr_c && ptr == PW'(5'h18) && acc_wdata[6:0] == 7'h00 |=> irq); // R9
endmodule

bind scsi_regif scsi_regif_chk #(.PW(scsi_regif_pkg::PTR_W)) u_chk (
  .clk (clk), .rst (rst), .acc_en (acc_en), .acc_wr (acc_wr),
  .acc_off (acc_off), .acc_wdata (acc_wdata), .rd_valid (rd_valid),
  .rd_data (rd_data), .irq (irq), .ptr (ptr_w)
);

// File: tb/scsi_regif_tb.sv
module scsi_regif_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       acc_en, acc_wr;
  logic [2:0] acc_off;
  logic [7:0] acc_wdata;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [7:0] tgt_present;
  logic       dir_out;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  scsi_regif u_dut (
    .clk (clk), .rst (rst), .acc_en (acc_en), .acc_wr (acc_wr),
    .acc_off (acc_off), .acc_wdata (acc_wdata), .rd_valid (rd_valid),
    .rd_data (rd_data), .tgt_present (tgt_present), .dir_out (dir_out),
    .irq (irq)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as read responses appear
  always @(negedge clk) begin
    if (!rst && rd_valid && !finished) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected read response", 8'h01, 8'h00);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic access(input logic wr, input logic [2:0] off, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_off = off; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] off, input logic [7:0] d);
    access(1'b1, off, d);
  endtask

  task automatic rd(input logic [2:0] off, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    access(1'b0, off, 8'h00);
  endtask

  task automatic setreg(input logic [7:0] a, input logic [7:0] v);
    wr(3'd3, a);
    wr(3'd7, v);
  endtask

  task automatic getreg(input logic [7:0] a, input logic [7:0] exp, input string tag);
    wr(3'd3, a);
    rd(3'd7, exp, tag);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    check(tag, {7'd0, irq}, {7'd0, exp});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_xfer(input int n, input logic [7:0] cmd, input logic d_out);
    dir_out = d_out;
    setreg(8'h12, 8'((n >> 16) & 255));
    wr(3'd7, 8'((n >> 8) & 255));
    wr(3'd7, 8'(n & 255));
    setreg(8'h18, cmd);
    chk_irq(1'b0, "R11 transfer-info clears irq");
    for (int i = 0; i < n - 1; i++) setreg(8'h19, 8'(i));
    chk_irq(1'b0, "R12 no irq before last byte");
    setreg(8'h19, 8'hC3);
    chk_irq(1'b1, "R12 irq on last byte");
    // pointer stepped past data register in the same cycle
    rd(3'd7, 8'h00, "R6 pointer past data reg after last byte");
    getreg(8'h19, 8'hC3, "R12 last byte stored");
    getreg(8'h17, d_out ? 8'h18 : 8'h19, "R12 completion status code");
    chk_irq(1'b0, "R7 status read clears irq");
  endtask

  initial begin
    acc_en = 0; acc_wr = 0; acc_off = 0; acc_wdata = 0;
    tgt_present = 8'b0000_0100; dir_out = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(3'd3, 8'h01, "R4 status byte idle");
    getreg(8'h17, 8'h00, "R1 status reg zero");
    getreg(8'h00, 8'h00, "R1 reg0 zero");

    // R6 write and auto-increment, R5 reads do not move pointer
    wr(3'd3, 8'h02);
    wr(3'd7, 8'h11);
    wr(3'd7, 8'h22);
    getreg(8'h02, 8'h11, "R5 read reg2");
    rd(3'd7, 8'h11, "R5 second read same reg");
    getreg(8'h03, 8'h22, "R6 second write went to reg3");
    wr(3'd3, 8'h1F);
    wr(3'd7, 8'h5A);
    wr(3'd7, 8'h6B);
    getreg(8'h00, 8'h6B, "R6 pointer wraps 1F to 00");
    getreg(8'h1F, 8'h5A, "R6 reg 1F stored");

    // R3 pointer masked to 5 bits
    getreg(8'h23, 8'h22, "R3 pointer 0x23 selects reg3");

    // R2 other offsets ignored
    wr(3'd3, 8'h02);
    wr(3'd1, 8'h1F);
    wr(3'd5, 8'h99);
    wr(3'd6, 8'h77);
    access(1'b0, 3'd0, 8'h00);
    rd(3'd7, 8'h11, "R2 stray offsets changed nothing");

    // R9 reset command, R4 status byte with irq
    setreg(8'h18, 8'h00);
    chk_irq(1'b1, "R9 reset command raises irq");
    rd(3'd3, 8'h81, "R4 status byte with irq");
    getreg(8'h00, 8'h6B, "R7 other read");
    chk_irq(1'b1, "R7 other register read keeps irq");
    getreg(8'h17, 8'h01, "R9 reset-done code");
    chk_irq(1'b0, "R7 status code read clears irq");

    // R8 control write
    setreg(8'h18, 8'h00);
    setreg(8'h01, 8'h04);
    chk_irq(1'b1, "R8 control without bit3 keeps irq");
    setreg(8'h01, 8'h08);
    chk_irq(1'b0, "R8 control bit3 clears irq");

    // R10 select with attention
    setreg(8'h15, 8'h02);
    setreg(8'h18, 8'h06);
    chk_irq(1'b1, "R10 select raises irq");
    getreg(8'h17, 8'h8A, "R10 target present code");
    setreg(8'h15, 8'h03);
    setreg(8'h18, 8'h06);
    getreg(8'h17, 8'h42, "R10 selection timeout code");
    setreg(8'h15, 8'hFA);
    setreg(8'h18, 8'h06);
    getreg(8'h17, 8'h8A, "R10 only low 3 id bits used");

    // R11/R12 transfers
    setreg(8'h18, 8'h00);
    run_xfer(3, 8'h20, 1'b1);
    run_xfer(258, 8'hA0, 1'b0);
    run_xfer(1, 8'h20, 1'b0);

    // R13 no second completion
    setreg(8'h19, 8'h44);
    setreg(8'h19, 8'h45);
    chk_irq(1'b0, "R13 writes after completion do not raise irq");

    // R1 synchronous reset mid-run
    setreg(8'h18, 8'h00);
    do_reset();
    chk_irq(1'b0, "R1 irq cleared by reset");
    rd(3'd7, 8'h00, "R1 pointer and reg0 cleared");
    getreg(8'h18, 8'h00, "R1 command reg cleared");

    repeat (4) @(negedge clk);
    check("R5 scoreboard drained", 8'(exp_q.size()), 8'h00);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule